// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block steps the digital reference code of a multiphase voltage regulator from zero up to its operating setpoint after power-up, then raises a ready flag. It waits until the supply-good input and both enable inputs are all high, and then waits a fixed delay. Next it ramps the reference up to a fixed boot level and holds it there until a qualified VID code is present. After that it ramps, up or down, to the VID target. Each step of a ramp is one code unit of 6.25 mV and is taken on a tick from an external soft-start oscillator.

If the VID code sampled at the end of the hold is the off code, the regulator shuts down. It stays shut down until one of the supply-good or enable inputs is cycled. The ready flag rises a fixed time after the reference settles on the target. Faults on undervoltage, overvoltage and overcurrent are ignored before the first ready. After that, any of them latches ready low until a full restart. All delays are counted in system clock cycles through parameters.

Top module: `vr_softstart_seq`

## Requirements
- R1: While rst_n is low, or while any of por_ok, en_a or en_b is low, dac_code is 0, vr_ready is 0 and shut_off is 0 at the next clock edge.
- R2: Once por_ok, en_a and en_b are all high, dac_code stays 0 for INIT_DLY clock cycles before the first ramp may begin.
- R3: During either ramp, dac_code changes by exactly one code per cycle in which ss_tick is high, and it does not change in any cycle in which ss_tick is low.
- R4: The first ramp stops at BOOT_CODE (default 176, i.e. 1.1 V in 6.25 mV steps). The code holds there for at least HOLD_DLY cycles and until vid_valid has been high for VID_QUAL consecutive cycles.
- R5: At the end of the hold, a vid_code other than 0 becomes the target. The second ramp counts up or down toward it and stops exactly on it, and a target equal to BOOT_CODE gives no steps.
- R6: At the end of the hold, vid_code 0 (the off code) drives dac_code to 0 and raises shut_off. Both stay that way while all enables remain high.
- R7: vr_ready rises READY_DLY+1 cycles after dac_code first equals the final target. It is 0 at all earlier points of the sequence.
- R8: uv_flt, ov_flt and oc_flt have no effect on any output before vr_ready has been high.
- R9: A fault input that is high while vr_ready is high clears vr_ready at the next edge. vr_ready then stays low, with dac_code unchanged, until an enable or por_ok is cycled.
- R10: Dropping any enable or por_ok takes priority over every other event in the same cycle, including a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on threshold |
| en_a | input | 1 | First enable |
| en_b | input | 1 | Second enable |
| ss_tick | input | 1 | One-cycle step tick from the soft-start oscillator |
| vid_code | input | DAC_W | Target code in 6.25 mV units, 0 = off |
| vid_valid | input | 1 | vid_code is valid |
| uv_flt | input | 1 | Undervoltage fault |
| ov_flt | input | 1 | Overvoltage fault |
| oc_flt | input | 1 | Overcurrent fault |
| dac_code | output | DAC_W | Reference DAC code |
| vr_ready | output | 1 | Regulator ready |
| shut_off | output | 1 | Latched off-code shutdown |

## Verification
Two pairs of events can fall in the same cycle. The first is loss of an enable together with a fault while ready is high, where the restart must win and the fault latch must not survive. The second is the end of the boot hold arriving while the oscillator tick is held high every cycle, where the hold level must not be stepped past before the VID target is taken. The bench provokes the first by dropping por_ok and raising a fault on the same falling edge. It provokes the second by running a whole sequence with the tick tied high and a late vid_valid. A behavioural model checks every output on every clock.

// File: rtl/vrss_pkg.sv
package vrss_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DELAY,
        ST_RAMP1,
        ST_HOLD,
        ST_RAMP2,
        ST_SETTLE,
        ST_READY,
        ST_FAULT,
        ST_OFF
    } seq_state_e;
endpackage

// File: rtl/vrss_timer.sv
module vrss_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == limit - CNT_W'(1));
    assign done   = run && at_end;

    always_comb begin
        if (!run)        cnt_d = '0;
        else if (at_end) cnt_d = cnt_q;
        else             cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/vrss_vid_qual.sv
module vrss_vid_qual #(
    parameter int QUAL_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic vid_valid,
    output logic done
);
    localparam int Q_W = $clog2(QUAL_N + 1);
    logic [Q_W-1:0] qual_d, qual_q;

    assign done = (qual_q == Q_W'(QUAL_N));

    always_comb begin
        if (!run || !vid_valid) qual_d = '0;
        else if (done)          qual_d = qual_q;
        else                    qual_d = qual_q + Q_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end
endmodule

// File: rtl/vrss_ramp.sv
module vrss_ramp #(
    parameter int DAC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DAC_W-1:0] target,
    output logic [DAC_W-1:0] code,
    output logic             at_target
);
    logic [DAC_W-1:0] code_d, code_q;

    assign code      = code_q;
    assign at_target = (code_q == target);

    always_comb begin
        code_d = code_q;
        if (clr)                                code_d = '0;
        else if (step && (code_q < target))     code_d = code_q + DAC_W'(1);
        else if (step && (code_q > target))     code_d = code_q - DAC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    // R3: no code movement without a tick
    p_no_move_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(code_q));
    // R3: at most one code per tick
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> ((code_q == $past(code_q) + DAC_W'(1)) ||
                            (code_q == $past(code_q) - DAC_W'(1)) ||
                            (code_q == $past(code_q))));
endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vrss_pkg::*;
#(
    parameter int DAC_W     = 8,
    parameter int BOOT_CODE = 176,
    parameter int INIT_DLY  = 340,
    parameter int HOLD_DLY  = 21,
    parameter int READY_DLY = 21,
    parameter int VID_QUAL  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             ss_tick,
    input  logic [DAC_W-1:0] vid_code,
    input  logic             vid_valid,
    input  logic             uv_flt,
    input  logic             ov_flt,
    input  logic             oc_flt,
    output logic [DAC_W-1:0] dac_code,
    output logic             vr_ready,
    output logic             shut_off
);
    localparam int MAX_A  = (INIT_DLY > HOLD_DLY) ? INIT_DLY : HOLD_DLY;
    localparam int MAX_D  = (MAX_A > READY_DLY) ? MAX_A : READY_DLY;
    localparam int CNT_W  = $clog2(MAX_D + 1);
    localparam logic [DAC_W-1:0] BOOT_V = DAC_W'(BOOT_CODE);
    localparam logic [DAC_W-1:0] OFF_V  = '0;

    typedef struct packed {
        seq_state_e       state;
        logic [DAC_W-1:0] tgt;
    } seq_regs_t;

    seq_regs_t        cur_q, nxt_d;
    logic             enable, fault_any;
    logic             tmr_run, tmr_done, qual_done;
    logic [CNT_W-1:0] tmr_limit;
    logic             ramp_step, ramp_clr, at_tgt;
    logic [DAC_W-1:0] ramp_tgt;

    assign enable    = por_ok & en_a & en_b;
    assign fault_any = uv_flt | ov_flt | oc_flt;

    always_comb begin
        nxt_d = cur_q;
        if (!enable) begin
            nxt_d.state = ST_IDLE;
        end else begin
            case (cur_q.state)
                ST_IDLE:   nxt_d.state = ST_DELAY;
                ST_DELAY:  if (tmr_done) nxt_d.state = ST_RAMP1;
                ST_RAMP1:  if (at_tgt)   nxt_d.state = ST_HOLD;
                ST_HOLD: begin
                    if (tmr_done && qual_done) begin
                        if (vid_code == OFF_V) begin
                            nxt_d.state = ST_OFF;
                        end else begin
                            nxt_d.state = ST_RAMP2;
                            nxt_d.tgt   = vid_code;
                        end
                    end
                end
                ST_RAMP2:  if (at_tgt)    nxt_d.state = ST_SETTLE;
                ST_SETTLE: if (tmr_done)  nxt_d.state = ST_READY;
                ST_READY:  if (fault_any) nxt_d.state = ST_FAULT;
                default:   nxt_d.state = cur_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.tgt   <= BOOT_V;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        tmr_run   = 1'b1;
        tmr_limit = CNT_W'(INIT_DLY);
        case (cur_q.state)
            ST_DELAY:  tmr_limit = CNT_W'(INIT_DLY);
            ST_HOLD:   tmr_limit = CNT_W'(HOLD_DLY);
            ST_SETTLE: tmr_limit = CNT_W'(READY_DLY);
            default:   tmr_run   = 1'b0;
        endcase
    end

    assign ramp_tgt  = (cur_q.state == ST_RAMP1) ? BOOT_V : cur_q.tgt;
    assign ramp_step = ss_tick && ((cur_q.state == ST_RAMP1) || (cur_q.state == ST_RAMP2));
    assign ramp_clr  = (nxt_d.state == ST_IDLE) || (nxt_d.state == ST_OFF);

    vrss_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    vrss_vid_qual #(.QUAL_N(VID_QUAL)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cur_q.state == ST_HOLD),
        .vid_valid (vid_valid),
        .done      (qual_done)
    );

    vrss_ramp #(.DAC_W(DAC_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ramp_clr),
        .step      (ramp_step),
        .target    (ramp_tgt),
        .code      (dac_code),
        .at_target (at_tgt)
    );

    assign vr_ready = (cur_q.state == ST_READY);
    assign shut_off = (cur_q.state == ST_OFF);

    // R1 / R10: losing an enable returns the outputs to rest
    p_disabled_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (dac_code == '0 && !vr_ready && !shut_off));
    // R4: the hold sits on the boot level
    p_hold_at_boot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_HOLD) |-> (dac_code == BOOT_V));
    // R6: off-code shutdown is sticky while enabled
    p_off_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_off && enable) |=> (shut_off && dac_code == '0));
    // R7: ready only on the final target
    p_ready_on_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vr_ready |-> (dac_code == cur_q.tgt));
    // R9: a fault while ready drops it
    p_fault_drops_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_ready && fault_any) |=> !vr_ready);
    // R9: latched fault keeps ready low and the code frozen
    p_fault_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_FAULT && enable) |=> (!vr_ready && $stable(dac_code)));
endmodule

// File: tb/sim_vr_softstart_seq.sv
`timescale 1ns/1ps
module sim_vr_softstart_seq;
    localparam int DW   = 8;
    localparam int BOOT = 176;
    localparam int TD_I = 340;
    localparam int TD_H = 21;
    localparam int TD_R = 21;
    localparam int QN   = 2;
    localparam int WDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_ok = 1'b0, en_a = 1'b0, en_b = 1'b0;
    logic          ss_tick = 1'b0;
    logic [DW-1:0] vid_code = '0;
    logic          vid_valid = 1'b0;
    logic          uv_flt = 1'b0, ov_flt = 1'b0, oc_flt = 1'b0;
    logic [DW-1:0] dac_code;
    logic          vr_ready, shut_off;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_per = 4;

    // behavioural reference
    int m_phase = 0;  // 0 idle 1 delay 2 ramp1 3 hold 4 ramp2 5 settle 6 ready 7 fault 8 off
    int m_dac = 0, m_cnt = 0, m_qual = 0, m_tgt = BOOT;

    vr_softstart_seq #(.DAC_W(DW), .BOOT_CODE(BOOT), .INIT_DLY(TD_I), .HOLD_DLY(TD_H),
                       .READY_DLY(TD_R), .VID_QUAL(QN)) u0 (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_a(en_a), .en_b(en_b),
        .ss_tick(ss_tick), .vid_code(vid_code), .vid_valid(vid_valid),
        .uv_flt(uv_flt), .ov_flt(ov_flt), .oc_flt(oc_flt),
        .dac_code(dac_code), .vr_ready(vr_ready), .shut_off(shut_off));

    always #2 clk = ~clk;

    function automatic string tag_of(int p);
        case (p)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5, 6: return "R7";
            7: return "R9";
            8: return "R6";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_dac = 0; m_cnt = 0; m_qual = 0;
        end else if (!(por_ok && en_a && en_b)) begin
            m_phase = 0; m_dac = 0; m_cnt = 0; m_qual = 0;
        end else begin
            case (m_phase)
                0: begin m_phase = 1; m_cnt = 0; end
                1: if (m_cnt == TD_I - 1) begin m_phase = 2; m_cnt = 0; end
                   else m_cnt++;
                2: if (m_dac == BOOT) m_phase = 3;
                   else if (ss_tick) m_dac++;
                3: if (m_cnt == TD_H - 1 && m_qual == QN) begin
                       m_cnt = 0; m_qual = 0;
                       if (vid_code == 0) begin m_phase = 8; m_dac = 0; end
                       else begin m_phase = 4; m_tgt = int'(vid_code); end
                   end else begin
                       if (m_cnt != TD_H - 1) m_cnt++;
                       if (!vid_valid) m_qual = 0;
                       else if (m_qual != QN) m_qual++;
                   end
                4: if (m_dac == m_tgt) begin m_phase = 5; m_cnt = 0; end
                   else if (ss_tick) m_dac = (m_dac < m_tgt) ? m_dac + 1 : m_dac - 1;
                5: if (m_cnt == TD_R - 1) m_phase = 6;
                   else m_cnt++;
                6: if (uv_flt || ov_flt || oc_flt) m_phase = 7;
                default: ;
            endcase
        end
    end

    // tick source, per-cycle comparison
    always @(negedge clk) begin
        checks++;
        if (int'(dac_code) != m_dac || vr_ready != (m_phase == 6) || shut_off != (m_phase == 8)) begin
            errors++;
            $display("FAIL %s cycle %0d: dac=%0d rdy=%0b off=%0b expected dac=%0d rdy=%0b off=%0b",
                     tag_of(m_phase), cyc, dac_code, vr_ready, shut_off,
                     m_dac, (m_phase == 6), (m_phase == 8));
        end
        cyc++;
        ss_tick = (tick_per <= 1) ? 1'b1 : ((cyc % tick_per) == 0);
    end

    always @(posedge clk) begin
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_phase(int p);
        int n = 0;
        while (m_phase != p && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic enable_all();
        @(negedge clk); por_ok = 1; en_a = 1; en_b = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", dac_code == 0 && !vr_ready && !shut_off, int'(dac_code), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1", dac_code == 0, int'(dac_code), 0);

        // up-ramp sequence, faults pulsed during soft-start
        vid_code = 8'd200; vid_valid = 1; tick_per = 4;
        enable_all();
        repeat (TD_I - 1) @(negedge clk);
        chk("R2", dac_code == 0, int'(dac_code), 0);
        wait_phase(2);
        repeat (50) @(negedge clk);
        ov_flt = 1; uv_flt = 1; @(negedge clk); ov_flt = 0; uv_flt = 0;
        wait_phase(4);
        oc_flt = 1; repeat (3) @(negedge clk); oc_flt = 0;
        wait_phase(6);
        chk("R8", vr_ready == 1, int'(vr_ready), 1);
        chk("R5", dac_code == 200, int'(dac_code), 200);
        repeat (5) @(negedge clk);
        ov_flt = 1; @(negedge clk); ov_flt = 0;
        repeat (6) @(negedge clk);
        chk("R9", vr_ready == 0 && dac_code == 200, int'(vr_ready), 0);
        en_a = 0; @(negedge clk);
        chk("R10", dac_code == 0 && !vr_ready, int'(dac_code), 0);

        // down-ramp with tick every cycle and late VID
        vid_code = 8'd150; vid_valid = 0; tick_per = 1;
        en_a = 1;
        wait_phase(3);
        repeat (40) @(negedge clk);
        chk("R4", dac_code == BOOT, int'(dac_code), BOOT);
        vid_valid = 1;
        wait_phase(6);
        chk("R5", dac_code == 150, int'(dac_code), 150);
        // enable loss and fault in the same cycle
        por_ok = 0; uv_flt = 1; @(negedge clk);
        uv_flt = 0;
        chk("R10", dac_code == 0 && !vr_ready, int'(dac_code), 0);
        por_ok = 1;

        // off code
        vid_code = 8'd0; vid_valid = 1; tick_per = 3;
        wait_phase(8);
        chk("R6", shut_off == 1 && dac_code == 0, int'(shut_off), 1);
        vid_code = 8'd176;
        repeat (30) @(negedge clk);
        chk("R6", shut_off == 1 && !vr_ready, int'(shut_off), 1);
        en_b = 0; @(negedge clk);
        chk("R1", shut_off == 0, int'(shut_off), 0);
        en_b = 1;
        wait_phase(6);
        chk("R5", dac_code == BOOT, int'(dac_code), BOOT);
        chk("R7", vr_ready == 1, int'(vr_ready), 1);

        // enable loss during the first ramp
        en_a = 0; @(negedge clk); en_a = 1;
        wait_phase(2);
        repeat (60) @(negedge clk);
        en_b = 0; @(negedge clk);
        chk("R10", dac_code == 0, int'(dac_code), 0);
        en_b = 1;
        repeat (10) @(negedge clk);
        chk("R2", dac_code == 0, int'(dac_code), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule